// File: doc/BRIEF.md
# Ethernet Individual Address Hash Filter

This block decides whether a received frame's destination MAC address belongs to this station. The address arrives one octet per cycle, first octet first, with a start marker on the first octet. Two tests run side by side. The first compares the full 48-bit address against a programmed station address. The second runs a bit-reflected CRC-32 over the six octets and uses the top six CRC bits as an index into a 64-bit hash table. The frame is accepted when either test hits.

Four 32-bit configuration registers hold the station address and the two halves of the hash table. They are written through a simple write strobe and read back through a combinational read port. The decision is registered and appears as a one-cycle pulse together with the accept flag, a group-address flag and the computed hash index. When the destination is a group address, the block always rejects it, so that a separate group filter can make that decision.

Top module: `mac_hash_filter`

## Requirements
- R1: After reset, all four configuration registers read as zero and `dec_valid` is low.
- R2: Register select codes are 0 = station octets 0..3, 1 = station octets 4..5, 2 = hash upper half, 3 = hash lower half. A write with `cfg_we` high updates the selected register at the clock edge, and `cfg_rdata` shows it afterwards. Select 1 keeps only `cfg_wdata[31:16]` and reads zero in bits 15:0.
- R3: The hash CRC starts at 0xFFFFFFFF. It takes each octet least significant bit first. On every bit it shifts right by one and XORs in 0xEDB88320 when the input bit differs from the old CRC bit 0. `dec_index` equals CRC bits 31:26 after the sixth octet.
- R4: A hash index of 32..63 selects bit (index−32) of register 2. A hash index of 0..31 selects bit index of register 3.
- R5: The station address holds octet 0 in register 0 bits 31:24, octet 1 in bits 23:16, octet 2 in bits 15:8 and octet 3 in bits 7:0. Octet 4 is in register 1 bits 31:24 and octet 5 in bits 23:16. A full 48-bit match is an exact hit.
- R6: For an individual address, `dec_accept` is 1 exactly when the exact test hits or the selected hash bit is 1.
- R7: When bit 0 of octet 0 is 1 (a group address), `dec_group` is 1 and `dec_accept` is 0, whatever the register contents.
- R8: `dec_valid` is high for exactly the one cycle that follows the clock edge at which the sixth octet was taken.
- R9: An octet with `rx_sof` low that arrives while no address is in progress is ignored. An octet with `rx_sof` high restarts collection and discards any partial address.
- R10: Cycles with `rx_valid` low between octets pause collection without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| rx_valid | input | 1 | Address octet valid |
| rx_sof | input | 1 | Marks octet 0 of an address |
| rx_byte | input | 8 | Address octet |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Address accepted |
| dec_group | output | 1 | Octet 0 had its group bit set |
| dec_index | output | 6 | Hash index of the address |

## Verification
The assertions assume that the octet stream is well framed. Every address starts with `rx_sof` on a valid octet, and two decisions are never closer than six octets apart. Under those assumptions the decision strobe can never appear on two cycles in a row. The stimulus always drives complete or deliberately restarted addresses, and it changes the configuration only between addresses. This means no decision ever mixes old and new table contents. Stray octets without a start marker are sent only while the block is idle.

// File: rtl/mac_filt_pkg.sv
package mac_filt_pkg;
  localparam int unsigned OCTET_W = 8;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef enum logic [1:0] {
    SEL_STA_HI  = 2'd0,
    SEL_STA_LO  = 2'd1,
    SEL_HASH_UP = 2'd2,
    SEL_HASH_LO = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/mac_filt_crc_step.sv
module mac_filt_crc_step #(
  parameter int unsigned CRC_W = 32,
  parameter int unsigned IN_W  = 8,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB8_8320
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [IN_W-1:0]  data_in,
  output logic [CRC_W-1:0] crc_out
);
  logic [CRC_W-1:0] stage [IN_W+1];

  assign stage[0] = crc_in;

  for (genvar i = 0; i < IN_W; i++) begin : g_bit
    logic fb;
    assign fb = data_in[i] ^ stage[i][0];
    assign stage[i+1] = (stage[i] >> 1) ^ (fb ? POLY : '0);
  end

  assign crc_out = stage[IN_W];
endmodule

// File: rtl/mac_filt_regs.sv
module mac_filt_regs
  import mac_filt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned TBL_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] sta_addr,
  output logic [TBL_W-1:0]  hash_tbl
);
  localparam int unsigned LO_W   = ADDR_W - DATA_W;
  localparam int unsigned HALF_W = TBL_W / 2;

  logic [DATA_W-1:0] sta_hi_q, sta_hi_d;
  logic [LO_W-1:0]   sta_lo_q, sta_lo_d;
  logic [HALF_W-1:0] hash_up_q, hash_up_d;
  logic [HALF_W-1:0] hash_lo_q, hash_lo_d;

  always_comb begin
    sta_hi_d  = sta_hi_q;
    sta_lo_d  = sta_lo_q;
    hash_up_d = hash_up_q;
    hash_lo_d = hash_lo_q;
    if (we) begin
      unique case (cfg_sel_e'(sel))
        SEL_STA_HI:  sta_hi_d  = wdata;
        SEL_STA_LO:  sta_lo_d  = wdata[DATA_W-1 -: LO_W];
        SEL_HASH_UP: hash_up_d = wdata[HALF_W-1:0];
        SEL_HASH_LO: hash_lo_d = wdata[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sta_hi_q  <= '0;
      sta_lo_q  <= '0;
      hash_up_q <= '0;
      hash_lo_q <= '0;
    end else begin
      sta_hi_q  <= sta_hi_d;
      sta_lo_q  <= sta_lo_d;
      hash_up_q <= hash_up_d;
      hash_lo_q <= hash_lo_d;
    end
  end

  always_comb begin
    unique case (cfg_sel_e'(sel))
      SEL_STA_HI:  rdata = sta_hi_q;
      SEL_STA_LO:  rdata = {sta_lo_q, {(DATA_W-LO_W){1'b0}}};
      SEL_HASH_UP: rdata = DATA_W'(hash_up_q);
      SEL_HASH_LO: rdata = DATA_W'(hash_lo_q);
      default:     rdata = '0;
    endcase
  end

  assign sta_addr = {sta_hi_q, sta_lo_q};
  assign hash_tbl = {hash_up_q, hash_lo_q};

  // R2: a write to the upper hash half is visible in the table next cycle
  assert_hash_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 2'd2) |=> (hash_tbl[TBL_W-1 -: HALF_W] == $past(wdata[HALF_W-1:0])));
endmodule

// File: rtl/mac_filt_seq.sv
module mac_filt_seq
  import mac_filt_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned CRC_W      = 32,
  parameter int unsigned HASH_BITS  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_sof,
  input  logic [OCTET_W-1:0]        in_byte,
  input  logic [ADDR_BYTES*OCTET_W-1:0] sta_addr,
  input  logic [(1<<HASH_BITS)-1:0] hash_tbl,
  output logic                      dec_valid,
  output logic                      dec_accept,
  output logic                      dec_group,
  output logic [HASH_BITS-1:0]      dec_index
);
  localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;
  localparam int unsigned CNT_W  = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [CRC_W-1:0]     crc_q, crc_d, crc_base;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic                 grp_q, grp_d;
  logic                 take, last;
  logic [HASH_BITS-1:0] idx_now;
  logic                 exact_now, hash_now;
  logic                 val_d, acc_d;

  assign take     = in_valid && (in_sof || cnt_q != '0);
  assign last     = take && (in_sof ? (ADDR_BYTES == 1) : (cnt_q == LAST_CNT));
  assign crc_base = in_sof ? CRC_SEED[CRC_W-1:0] : crc_q;

  mac_filt_crc_step #(
    .CRC_W(CRC_W), .IN_W(OCTET_W), .POLY(CRC_POLY[CRC_W-1:0])
  ) u_step (
    .crc_in(crc_base), .data_in(in_byte), .crc_out(crc_d)
  );

  always_comb begin
    if (in_sof) begin
      addr_d = ADDR_W'(in_byte);
      grp_d  = in_byte[0];
    end else begin
      addr_d = {addr_q[ADDR_W-OCTET_W-1:0], in_byte};
      grp_d  = grp_q;
    end
    if (last)      cnt_d = '0;
    else if (take) cnt_d = in_sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
    else           cnt_d = cnt_q;
    idx_now   = crc_d[CRC_W-1 -: HASH_BITS];
    hash_now  = hash_tbl[idx_now];
    exact_now = (addr_d == sta_addr);
    acc_d     = !grp_d && (exact_now || hash_now);
    val_d     = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      crc_q  <= '0;
      addr_q <= '0;
      grp_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (take) begin
        crc_q  <= crc_d;
        addr_q <= addr_d;
        grp_q  <= grp_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_group  <= 1'b0;
      dec_index  <= '0;
    end else begin
      dec_valid <= val_d;
      if (last) begin
        dec_accept <= acc_d;
        dec_group  <= grp_d;
        dec_index  <= idx_now;
      end
    end
  end

  // R9: the octet counter never leaves its legal range
  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(ADDR_BYTES));

  // R7: a group decision is never an accept
  assert_group_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_group) |-> !dec_accept);

  // R8: the strobe follows the edge that took a final octet
  assert_strobe_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(take));

  if (ADDR_BYTES > 1) begin : g_pulse
    // R8: the strobe lasts one cycle
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);
  end
endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
  import mac_filt_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [1:0]           cfg_sel,
  input  logic [DATA_W-1:0]    cfg_wdata,
  output logic [DATA_W-1:0]    cfg_rdata,
  input  logic                 rx_valid,
  input  logic                 rx_sof,
  input  logic [7:0]           rx_byte,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output logic                 dec_group,
  output logic [HASH_BITS-1:0] dec_index
);
  localparam int unsigned ADDR_W = ADDR_BYTES * OCTET_W;
  localparam int unsigned TBL_W  = 1 << HASH_BITS;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] sta_addr;
  logic [TBL_W-1:0]  hash_tbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mac_filt_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TBL_W(TBL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .sta_addr(sta_addr), .hash_tbl(hash_tbl)
  );

  mac_filt_seq #(
    .ADDR_BYTES(ADDR_BYTES), .CRC_W(32), .HASH_BITS(HASH_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(rx_valid), .in_sof(rx_sof), .in_byte(rx_byte),
    .sta_addr(sta_addr), .hash_tbl(hash_tbl),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_group(dec_group), .dec_index(dec_index)
  );

  // R1: no decision while the internal reset is held
  assert_quiet_reset_R1: assert property (@(posedge clk)
    !rst_int_n |=> !dec_valid);
endmodule

// File: tb/sim_mac_hash_filter.sv
module sim_mac_hash_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        rx_valid, rx_sof;
  logic [7:0]  rx_byte;
  logic        dec_valid, dec_accept, dec_group;
  logic [5:0]  dec_index;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_hash_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_group(dec_group), .dec_index(dec_index)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] o = a[47-8*b -: 8];
      for (int k = 0; k < 8; k++) begin
        logic d = o[k] ^ c[0];
        c = c >> 1;
        if (d) c = c ^ 32'hEDB8_8320;
      end
    end
    return c[31:26];
  endfunction

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [31:0] e, input string rq);
    @(negedge clk);
    cfg_sel = s;
    #1;
    chk(cfg_rdata === e, rq, cfg_rdata, e);
  endtask

  task automatic set_table(input logic [63:0] t);
    wr(2'd2, t[63:32]);
    wr(2'd3, t[31:0]);
  endtask

  // ends at the negedge right after the edge that took the last octet
  task automatic send(input logic [47:0] a, input int gap);
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (b == 0); rx_byte = a[47-8*b -: 8];
      if (b < 5) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          rx_valid = 1'b0; rx_sof = 1'b0;
        end
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  task automatic expect_dec(input bit acc, input bit grp, input logic [5:0] idx, input string rq);
    chk(dec_valid === 1'b1, {rq, " R8 strobe"}, dec_valid, 1);
    chk(dec_accept === acc, {rq, " accept"}, dec_accept, acc);
    chk(dec_group === grp, {rq, " R7 group"}, dec_group, grp);
    chk(dec_index === idx, {rq, " R3 index"}, dec_index, idx);
    @(negedge clk);
    chk(dec_valid === 1'b0, {rq, " R8 one cycle"}, dec_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8 actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] sta, a;
    logic [5:0]  ix;
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    rx_valid = 0; rx_sof = 0; rx_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) rd_chk(2'(s), 32'h0, "R1 reg reset");
    chk(dec_valid === 1'b0, "R1 strobe low", dec_valid, 0);

    // R2 register access
    wr(2'd0, 32'hA1B2_C3D4); rd_chk(2'd0, 32'hA1B2_C3D4, "R2 sel0");
    wr(2'd1, 32'h1234_ABCD); rd_chk(2'd1, 32'h1234_0000, "R2 sel1 low ignored");
    wr(2'd2, 32'hDEAD_BEEF); rd_chk(2'd2, 32'hDEAD_BEEF, "R2 sel2");
    wr(2'd3, 32'h0BAD_F00D); rd_chk(2'd3, 32'h0BAD_F00D, "R2 sel3");

    // R5 exact match with empty hash table
    sta = 48'h02_11_22_33_44_55;
    wr(2'd0, sta[47:16]); wr(2'd1, {sta[15:0], 16'h0});
    set_table(64'h0);
    send(sta, 0);
    expect_dec(1'b1, 1'b0, ref_index(sta), "R5 exact hit");
    a = sta ^ 48'h00_00_00_00_00_80;
    send(a, 0);
    expect_dec(1'b0, 1'b0, ref_index(a), "R5 octet5 miss");
    a = sta ^ 48'h04_00_00_00_00_00;
    send(a, 0);
    expect_dec(1'b0, 1'b0, ref_index(a), "R5 octet0 miss");

    // R3 R4 R6 sweep of hash positions
    for (int i = 0; i < 64; i++) begin
      a  = {8'h02, 8'h10, 8'h20, 8'(i * 7), 8'h40, 8'(i)};
      ix = ref_index(a);
      set_table(64'h1 << ix);
      send(a, 0);
      expect_dec(1'b1, 1'b0, ix, "R4 R6 selected bit set");
      set_table(~(64'h1 << ix));
      send(a, 0);
      expect_dec(1'b0, 1'b0, ix, "R4 R6 selected bit clear");
    end

    // R7 group address forced reject
    set_table({64{1'b1}});
    a = 48'h03_11_22_33_44_55;
    wr(2'd0, a[47:16]); wr(2'd1, {a[15:0], 16'h0});
    send(a, 0);
    expect_dec(1'b0, 1'b1, ref_index(a), "R7 group reject");

    // R10 gaps between octets
    set_table(64'h0);
    wr(2'd0, sta[47:16]); wr(2'd1, {sta[15:0], 16'h0});
    send(sta, 3);
    expect_dec(1'b1, 1'b0, ref_index(sta), "R10 gapped octets");

    // R9 stray octets ignored while idle
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'(k);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    chk(dec_valid === 1'b0, "R9 stray octets no decision", dec_valid, 0);
    @(negedge clk);
    chk(dec_valid === 1'b0, "R9 stray octets no decision", dec_valid, 0);

    // R9 restart discards partial address
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = 8'hF0 + 8'(k);
    end
    send(sta, 0);
    expect_dec(1'b1, 1'b0, ref_index(sta), "R9 restart");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule